// File: doc/BRIEF.md
# System Address Decoder with Control Flags

This block decodes a 16-bit processor address bus, qualified by a memory request strobe and separate read and write strobes, into chip selects for the boot ROM, main RAM, the optional RAM expansion, video RAM, the parallel peripheral interface, the interval timer and a scroll (roll) control window. The selects are combinational, and at most one is active at a time.

The block also holds three system control bits. A swap flag is set or cleared by any access to its own set or clear address, whatever the data. A reverse-video flag works the same way, with one address for normal display and one for reverse display. A sound enable is latched from data bit 0 on a write to the system status port. While the swap flag is set, the 4 KB boot ROM window and a 4 KB RAM block at a parameterised base exchange places.

For reads, the block itself drives the data bus in the I/O page, except where the peripheral interface or the timer answers. At the status port it returns live timing inputs together with the sound latch. Every other such I/O address reads 0xFF.

Top module: `sysdec_top`

## Requirements
- R1: With the swap flag clear, an access to 0x0000–0x0FFF asserts `sel_rom`.
- R2: Accesses to 0x1000–0x8FFF assert `sel_ram`. Accesses to 0x9000–0xCFFF assert `sel_ramx` only while `exp_present` is high; otherwise they assert no select.
- R3: Accesses to 0xD000–0xDFFF assert `sel_vram`. No RAM select is asserted at or above 0xD000.
- R4: 0xE000–0xE003 assert `sel_ppi` and 0xE004–0xE007 assert `sel_pit`. `reg_idx` equals address bits 1:0, so the fourth location of each is the mode control register.
- R5: A select or `roll_stb` is asserted only while `mreq` is high and `rd` or `wr` is high. At most one of the seven is high in any cycle.
- R6: Any access (read or write, any data) to 0xE00C sets `swap_flag` and any access to 0xE010 clears it, visible from the next clock. A strobe with `mreq` low has no effect on it.
- R7: While `swap_flag` is set, 0x0000–0x0FFF is decoded as the 4 KB block at `SWAP_BASE` (default 0xC000, giving `sel_ramx` with `exp_present` high and no select with it low), and `SWAP_BASE`–`SWAP_BASE`+0xFFF asserts `sel_rom`.
- R8: Any access to 0xE015 sets `reverse_flag` and any access to 0xE014 clears it, visible from the next clock.
- R9: A write to 0xE008 latches `wdata` bit 0 into `sound_en`. A read of 0xE008 drives `rdata_oe` high and `rdata` = {`tempo_stat`, `hblank`, 5'b00000, `sound_en`} (bit 7 down to bit 0).
- R10: A read of any address in 0xE000–0xEFFF outside the peripheral interface, the timer and 0xE008 drives `rdata_oe` high and `rdata` = 0xFF. Elsewhere `rdata_oe` is low and `rdata` is 0x00.
- R11: Accesses to 0xE200–0xE2FF assert `roll_stb`.
- R12: Reset clears `swap_flag`, `reverse_flag` and `sound_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Address bus |
| mreq | input | 1 | Memory request, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| wdata | input | 8 | Write data bus |
| exp_present | input | 1 | RAM expansion fitted |
| tempo_stat | input | 1 | Tempo timer status, live |
| hblank | input | 1 | Horizontal blank, live |
| sel_rom | output | 1 | Boot ROM select |
| sel_ram | output | 1 | Main RAM select |
| sel_ramx | output | 1 | Expansion RAM select |
| sel_vram | output | 1 | Video RAM select |
| sel_ppi | output | 1 | Parallel peripheral interface select |
| sel_pit | output | 1 | Interval timer select |
| reg_idx | output | 2 | Register index for the peripheral interface and timer |
| roll_stb | output | 1 | Scroll window strobe |
| rdata | output | 8 | Read data from the block |
| rdata_oe | output | 1 | Block drives the read data |
| swap_flag | output | 1 | ROM/RAM swap state |
| reverse_flag | output | 1 | Reverse video state |
| sound_en | output | 1 | Sound enable latch |

## Verification
The bench builds the block with its default parameters: swap remapping enabled and `SWAP_BASE` at 0xC000. Because that base lies in the optional region, a swapped boot window lands on `sel_ramx` or on no select, depending on `exp_present`, so both the swap path and the expansion gating are exercised in one setup. The default base also places the relocated ROM at the top of the optional range, which checks that a swapped block takes priority over the plain RAM decode.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [15:0] RAM_LO   = 16'h1000;
    localparam logic [15:0] RAMX_LO  = 16'h9000;
    localparam logic [15:0] VRAM_LO  = 16'hD000;
    localparam logic [15:0] IO_LO    = 16'hE000;
    localparam logic [15:0] IO_END   = 16'hF000;
    localparam logic [15:0] STAT_ADR = 16'hE008;
    localparam logic [15:0] SWSET_AD = 16'hE00C;
    localparam logic [15:0] SWCLR_AD = 16'hE010;
    localparam logic [15:0] NORM_AD  = 16'hE014;
    localparam logic [15:0] REV_AD   = 16'hE015;
    localparam logic [7:0]  ROLL_PG  = 8'hE2;
    localparam logic [9:0]  PPI_QUAD = 10'd0;
    localparam logic [9:0]  PIT_QUAD = 10'd1;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_ROM,
        RG_RAM,
        RG_RAMX,
        RG_VRAM,
        RG_PPI,
        RG_PIT,
        RG_STAT,
        RG_SWSET,
        RG_SWCLR,
        RG_NORM,
        RG_REV,
        RG_ROLL,
        RG_IOMISC
    } region_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic ramx;
        logic vram;
        logic ppi;
        logic pit;
        logic roll;
    } csel_t;

    function automatic region_e classify(input logic [15:0] a, input logic exp_on);
        region_e r;
        if (a < RAM_LO)
            r = RG_ROM;
        else if (a < RAMX_LO)
            r = RG_RAM;
        else if (a < VRAM_LO)
            r = exp_on ? RG_RAMX : RG_NONE;
        else if (a < IO_LO)
            r = RG_VRAM;
        else if (a < IO_END) begin
            if (a[11:2] == PPI_QUAD)
                r = RG_PPI;
            else if (a[11:2] == PIT_QUAD)
                r = RG_PIT;
            else if (a == STAT_ADR)
                r = RG_STAT;
            else if (a == SWSET_AD)
                r = RG_SWSET;
            else if (a == SWCLR_AD)
                r = RG_SWCLR;
            else if (a == NORM_AD)
                r = RG_NORM;
            else if (a == REV_AD)
                r = RG_REV;
            else if (a[15:8] == ROLL_PG)
                r = RG_ROLL;
            else
                r = RG_IOMISC;
        end else
            r = RG_NONE;
        return r;
    endfunction

    function automatic logic [15:0] swap_remap(input logic [15:0] a,
                                               input logic        swapped,
                                               input logic [3:0]  base_blk);
        logic [15:0] m;
        m = a;
        if (swapped) begin
            if (a[15:12] == 4'h0)
                m = {base_blk, a[11:0]};
            else if (a[15:12] == base_blk)
                m = {4'h0, a[11:0]};
        end
        return m;
    endfunction

    function automatic logic is_self_read(input region_e r);
        return (r == RG_STAT) || (r == RG_SWSET) || (r == RG_SWCLR) ||
               (r == RG_NORM) || (r == RG_REV)   || (r == RG_ROLL)  ||
               (r == RG_IOMISC);
    endfunction

endpackage

// File: rtl/sysdec_map.sv
module sysdec_map
    import sysdec_pkg::*;
#(
    parameter logic [15:0] SWAP_BASE = 16'hC000,
    parameter bit          SWAP_EN   = 1'b1
) (
    input  logic [15:0] addr,
    input  logic        swap_flag,
    input  logic        exp_present,
    output region_e     region
);
    localparam logic [3:0] BASE_BLK = SWAP_BASE[15:12];

    logic [15:0] eff_addr;

    generate
        if (SWAP_EN) begin : g_swap
            always_comb eff_addr = swap_remap(addr, swap_flag, BASE_BLK);
        end else begin : g_plain
            logic unused_swap;
            always_comb unused_swap = swap_flag;
            always_comb eff_addr = addr;
        end
    endgenerate

    always_comb region = classify(eff_addr, exp_present);

endmodule

// File: rtl/sysdec_csel.sv
module sysdec_csel
    import sysdec_pkg::*;
(
    input  region_e region,
    input  logic    access,
    output csel_t   csel
);
    always_comb begin
        csel = '0;
        if (access) begin
            case (region)
                RG_ROM:  csel.rom  = 1'b1;
                RG_RAM:  csel.ram  = 1'b1;
                RG_RAMX: csel.ramx = 1'b1;
                RG_VRAM: csel.vram = 1'b1;
                RG_PPI:  csel.ppi  = 1'b1;
                RG_PIT:  csel.pit  = 1'b1;
                RG_ROLL: csel.roll = 1'b1;
                default: csel = '0;
            endcase
        end
    end
endmodule

// File: rtl/sysdec_ctrl.sv
module sysdec_ctrl
    import sysdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  region_e region,
    input  logic    access,
    input  logic    wr_cyc,
    input  logic    wbit0,
    output logic    swap_flag,
    output logic    reverse_flag,
    output logic    sound_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            swap_flag    <= 1'b0;
            reverse_flag <= 1'b0;
            sound_en     <= 1'b0;
        end else if (access) begin
            case (region)
                RG_SWSET: swap_flag    <= 1'b1;
                RG_SWCLR: swap_flag    <= 1'b0;
                RG_NORM:  reverse_flag <= 1'b0;
                RG_REV:   reverse_flag <= 1'b1;
                RG_STAT:  if (wr_cyc) sound_en <= wbit0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sysdec_rdmux.sv
module sysdec_rdmux
    import sysdec_pkg::*;
(
    input  region_e     region,
    input  logic        rd_cyc,
    input  logic        tempo_stat,
    input  logic        hblank,
    input  logic        sound_en,
    output logic [7:0]  rdata,
    output logic        rdata_oe
);
    always_comb begin
        rdata_oe = rd_cyc && is_self_read(region);
        if (!rdata_oe)
            rdata = 8'h00;
        else if (region == RG_STAT)
            rdata = {tempo_stat, hblank, 5'b00000, sound_en};
        else
            rdata = 8'hFF;
    end
endmodule

// File: rtl/sysdec_top.sv
module sysdec_top
    import sysdec_pkg::*;
#(
    parameter logic [15:0] SWAP_BASE = 16'hC000,
    parameter bit          SWAP_EN   = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        mreq,
    input  logic        rd,
    input  logic        wr,
    input  logic [7:0]  wdata,
    input  logic        exp_present,
    input  logic        tempo_stat,
    input  logic        hblank,
    output logic        sel_rom,
    output logic        sel_ram,
    output logic        sel_ramx,
    output logic        sel_vram,
    output logic        sel_ppi,
    output logic        sel_pit,
    output logic [1:0]  reg_idx,
    output logic        roll_stb,
    output logic [7:0]  rdata,
    output logic        rdata_oe,
    output logic        swap_flag,
    output logic        reverse_flag,
    output logic        sound_en
);
    region_e region;
    csel_t   csel;
    logic    access;
    logic    rd_cyc;
    logic    wr_cyc;
    logic [7:1] unused_wdata;

    assign access       = mreq && (rd || wr);
    assign rd_cyc       = mreq && rd;
    assign wr_cyc       = mreq && wr;
    assign unused_wdata = wdata[7:1];

    sysdec_map #(.SWAP_BASE(SWAP_BASE), .SWAP_EN(SWAP_EN)) u_map (
        .addr        (addr),
        .swap_flag   (swap_flag),
        .exp_present (exp_present),
        .region      (region)
    );

    sysdec_csel u_csel (
        .region (region),
        .access (access),
        .csel   (csel)
    );

    sysdec_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .region       (region),
        .access       (access),
        .wr_cyc       (wr_cyc),
        .wbit0        (wdata[0]),
        .swap_flag    (swap_flag),
        .reverse_flag (reverse_flag),
        .sound_en     (sound_en)
    );

    sysdec_rdmux u_rdmux (
        .region     (region),
        .rd_cyc     (rd_cyc),
        .tempo_stat (tempo_stat),
        .hblank     (hblank),
        .sound_en   (sound_en),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe)
    );

    assign sel_rom  = csel.rom;
    assign sel_ram  = csel.ram;
    assign sel_ramx = csel.ramx;
    assign sel_vram = csel.vram;
    assign sel_ppi  = csel.ppi;
    assign sel_pit  = csel.pit;
    assign roll_stb = csel.roll;
    assign reg_idx  = addr[1:0];

endmodule

// File: rtl/sysdec_chk.sv
module sysdec_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        mreq,
    input logic        rd,
    input logic        wr,
    input logic        wdata0,
    input logic        exp_present,
    input logic        tempo_stat,
    input logic        hblank,
    input logic [6:0]  sels,
    input logic        sel_ramx,
    input logic        sel_vram,
    input logic        roll_stb,
    input logic [7:0]  rdata,
    input logic        rdata_oe,
    input logic        swap_flag,
    input logic        reverse_flag,
    input logic        sound_en
);
    logic acc;
    assign acc = mreq && (rd || wr);

    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sels));

    assert_sel_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !acc |-> (sels == 7'b0));

    assert_ramx_gated_R2: assert property (@(posedge clk) disable iff (rst)
        !exp_present |-> !sel_ramx);

    assert_vram_window_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && addr[15:12] == 4'hD) |-> sel_vram);

    assert_roll_window_R11: assert property (@(posedge clk) disable iff (rst)
        (acc && addr[15:8] == 8'hE2) |-> roll_stb);

    assert_swap_set_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && addr == 16'hE00C) |=> swap_flag);

    assert_swap_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && addr == 16'hE010) |=> !swap_flag);

    assert_rev_set_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && addr == 16'hE015) |=> reverse_flag);

    assert_rev_clr_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && addr == 16'hE014) |=> !reverse_flag);

    assert_sound_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (mreq && wr && addr == 16'hE008) |=> (sound_en == $past(wdata0)));

    assert_status_read_R9: assert property (@(posedge clk) disable iff (rst)
        (mreq && rd && addr == 16'hE008) |->
            (rdata_oe && rdata[7] == tempo_stat && rdata[6] == hblank && rdata[0] == sound_en));

    assert_flags_reset_R12: assert property (@(posedge clk)
        rst |=> (!swap_flag && !reverse_flag && !sound_en));

endmodule

bind sysdec_top sysdec_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .mreq         (mreq),
    .rd           (rd),
    .wr           (wr),
    .wdata0       (wdata[0]),
    .exp_present  (exp_present),
    .tempo_stat   (tempo_stat),
    .hblank       (hblank),
    .sels         ({sel_rom, sel_ram, sel_ramx, sel_vram, sel_ppi, sel_pit, roll_stb}),
    .sel_ramx     (sel_ramx),
    .sel_vram     (sel_vram),
    .roll_stb     (roll_stb),
    .rdata        (rdata),
    .rdata_oe     (rdata_oe),
    .swap_flag    (swap_flag),
    .reverse_flag (reverse_flag),
    .sound_en     (sound_en)
);

// File: tb/sysdec_top_test.sv
module sysdec_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    // {addr, mreq, rd, wr, exp_present, {rom,ram,ramx,vram,ppi,pit,roll}}
    localparam logic [26:0] VEC [0:NVEC-1] = '{
        {16'h0000, 4'b1101, 7'b1000000},  // R1
        {16'h0FFF, 4'b1101, 7'b1000000},  // R1
        {16'h1000, 4'b1011, 7'b0100000},  // R2
        {16'h8FFF, 4'b1101, 7'b0100000},  // R2
        {16'h9000, 4'b1101, 7'b0010000},  // R2
        {16'hCFFF, 4'b1011, 7'b0010000},  // R2
        {16'h9000, 4'b1100, 7'b0000000},  // R2
        {16'hCFFF, 4'b1100, 7'b0000000},  // R2
        {16'hD000, 4'b1101, 7'b0001000},  // R3
        {16'hDFFF, 4'b1011, 7'b0001000},  // R3
        {16'hE000, 4'b1101, 7'b0000100},  // R4
        {16'hE003, 4'b1101, 7'b0000100},  // R4
        {16'hE004, 4'b1101, 7'b0000010},  // R4
        {16'hE007, 4'b1101, 7'b0000010},  // R4
        {16'hE200, 4'b1101, 7'b0000001},  // R11
        {16'hE2FF, 4'b1101, 7'b0000001},  // R11
        {16'hE300, 4'b1101, 7'b0000000},  // R3
        {16'hF000, 4'b1101, 7'b0000000},  // R3
        {16'h0000, 4'b0101, 7'b0000000},  // R5
        {16'h1000, 4'b1001, 7'b0000000},  // R5
        {16'hE005, 4'b0011, 7'b0000000},  // R5
        {16'hE008, 4'b1101, 7'b0000000}   // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0;
    logic        mreq = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = 8'h0;
    logic        exp_present = 1'b1;
    logic        tempo_stat = 1'b0;
    logic        hblank = 1'b0;
    logic        sel_rom, sel_ram, sel_ramx, sel_vram, sel_ppi, sel_pit, roll_stb;
    logic [1:0]  reg_idx;
    logic [7:0]  rdata;
    logic        rdata_oe, swap_flag, reverse_flag, sound_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysdec_top uut (
        .clk(clk), .rst(rst), .addr(addr), .mreq(mreq), .rd(rd), .wr(wr),
        .wdata(wdata), .exp_present(exp_present), .tempo_stat(tempo_stat),
        .hblank(hblank), .sel_rom(sel_rom), .sel_ram(sel_ram), .sel_ramx(sel_ramx),
        .sel_vram(sel_vram), .sel_ppi(sel_ppi), .sel_pit(sel_pit), .reg_idx(reg_idx),
        .roll_stb(roll_stb), .rdata(rdata), .rdata_oe(rdata_oe), .swap_flag(swap_flag),
        .reverse_flag(reverse_flag), .sound_en(sound_en)
    );

    function automatic logic [6:0] sels();
        return {sel_rom, sel_ram, sel_ramx, sel_vram, sel_ppi, sel_pit, roll_stb};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic m, input logic r,
                       input logic w, input logic [7:0] d);
        @(negedge clk);
        addr = a; mreq = m; rd = r; wr = w; wdata = d;
        #1;
    endtask

    task automatic rel();
        @(negedge clk);
        mreq = 1'b0; rd = 1'b0; wr = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R12 swap after reset", {31'b0, swap_flag}, 0);
        check("R12 reverse after reset", {31'b0, reverse_flag}, 0);
        check("R12 sound after reset", {31'b0, sound_en}, 0);
        check("R5 idle selects", {25'b0, sels()}, 0);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [26:0] v;
            v = VEC[i];
            @(negedge clk);
            addr = v[26:11]; mreq = v[10]; rd = v[9]; wr = v[8]; exp_present = v[7];
            wdata = 8'h00;
            #1;
            check($sformatf("R1-decode vec %0d (R1 R2 R3 R4 R5 R11)", i), {25'b0, sels()}, {25'b0, v[6:0]});
            if (v[2] || v[1])
                check("R4 reg_idx", {30'b0, reg_idx}, {30'b0, v[12:11]});
        end
        rel();
        exp_present = 1'b1;

        // sound latch and status read
        put(16'hE008, 1, 0, 1, 8'h01); rel();
        check("R9 sound set", {31'b0, sound_en}, 1);
        tempo_stat = 1'b1; hblank = 1'b0;
        put(16'hE008, 1, 1, 0, 8'h00);
        check("R9 status oe", {31'b0, rdata_oe}, 1);
        check("R9 status 0x81", {24'b0, rdata}, 32'h81);
        rel();
        put(16'hE008, 1, 0, 1, 8'hFE); rel();
        check("R9 sound cleared by bit0", {31'b0, sound_en}, 0);
        tempo_stat = 1'b0; hblank = 1'b1;
        put(16'hE008, 1, 1, 0, 8'h00);
        check("R9 status 0x40", {24'b0, rdata}, 32'h40);
        rel();

        // I/O filler reads
        put(16'hE00A, 1, 1, 0, 8'h00);
        check("R10 misc io oe", {31'b0, rdata_oe}, 1);
        check("R10 misc io 0xFF", {24'b0, rdata}, 32'hFF);
        rel();
        put(16'hE250, 1, 1, 0, 8'h00);
        check("R10 roll read 0xFF", {24'b0, rdata}, 32'hFF);
        rel();
        put(16'hE003, 1, 1, 0, 8'h00);
        check("R10 ppi no oe", {31'b0, rdata_oe}, 0);
        check("R10 ppi rdata 0", {24'b0, rdata}, 0);
        rel();
        put(16'h1000, 1, 1, 0, 8'h00);
        check("R10 ram no oe", {31'b0, rdata_oe}, 0);
        rel();
        put(16'hE00A, 0, 1, 0, 8'h00);
        check("R10 no mreq no oe", {31'b0, rdata_oe}, 0);
        rel();

        // swap flag
        put(16'hE00C, 1, 1, 0, 8'h00); rel();
        check("R6 swap set by read", {31'b0, swap_flag}, 1);
        put(16'hE010, 0, 0, 1, 8'h00); rel();
        check("R6 no mreq keeps swap", {31'b0, swap_flag}, 1);
        put(16'h0123, 1, 1, 0, 8'h00);
        check("R7 low window to ramx", {25'b0, sels()}, 32'b0010000);
        rel();
        put(16'hC456, 1, 1, 0, 8'h00);
        check("R7 base block to rom", {25'b0, sels()}, 32'b1000000);
        rel();
        put(16'h1000, 1, 0, 1, 8'h00);
        check("R7 other ram unchanged", {25'b0, sels()}, 32'b0100000);
        rel();
        exp_present = 1'b0;
        put(16'h0000, 1, 1, 0, 8'h00);
        check("R7 low window no exp", {25'b0, sels()}, 0);
        rel();
        exp_present = 1'b1;
        put(16'hE010, 1, 0, 1, 8'hFF); rel();
        check("R6 swap cleared", {31'b0, swap_flag}, 0);
        put(16'h0000, 1, 1, 0, 8'h00);
        check("R1 rom back after clear", {25'b0, sels()}, 32'b1000000);
        rel();

        // reverse flag
        put(16'hE015, 1, 0, 1, 8'h00); rel();
        check("R8 reverse set", {31'b0, reverse_flag}, 1);
        put(16'hE014, 1, 1, 0, 8'h00); rel();
        check("R8 reverse cleared", {31'b0, reverse_flag}, 0);

        // reset in service
        put(16'hE00C, 1, 0, 1, 8'h00); rel();
        put(16'hE015, 1, 0, 1, 8'h00); rel();
        put(16'hE008, 1, 0, 1, 8'h01); rel();
        check("R12 pre-reset flags", {29'b0, swap_flag, reverse_flag, sound_en}, 32'b111);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #1;
        check("R12 reset clears flags", {29'b0, swap_flag, reverse_flag, sound_en}, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule